// File: doc/BRIEF.md
# ECC Check-Byte Fault Injector

This unit sits on the write path of a memory controller, between the SECDED encoder and the memory array. In normal operation it passes the encoder's 8-bit check byte through without change. Software can arm a one-shot fault. The next write beat that leaves the encoder then has a chosen 8-bit pattern XORed into its check byte. A later read of that location shows a predictable correctable or uncorrectable error.

All faults are expressed as check-byte flips. To fake a single flipped data bit, software loads the syndrome column for that bit. To flip one check bit, it loads a one-hot value. To cause a double-bit (uncorrectable) error, it loads 0x03 and leaves writeback clear. The writeback flag is reported alongside the corrupted beat, so the controller knows the corrected data may be written back after the error is found.

Software arms the unit through a 32-bit register port. Before arming, it polls a status bit that reflects pending controller writes. The trigger clears itself once the fault has been applied, so exactly one write is affected.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: After reset, the control register reads 0, the status register reads 0 while no writes are pending, and the check byte passes through unchanged.
- R2: While no injection is armed, `mem_check_o` equals `enc_check_i` and `mem_wb_en_o` is 0.
- R3: A write to the control register (byte offset 0) while idle updates three fields, and a read of that register returns them at the same positions. Bits 23:16 set the XOR pattern, bit 24 sets the writeback flag, and bit 8 sets the trigger. A write with bit 8 equal to 1 arms the injection.
- R4: While armed, a beat with `enc_valid_i` high leaves the unit with `mem_check_o = enc_check_i ^ pattern` in that same cycle. The pattern 0x03 flips exactly check bits 1 and 0.
- R5: The clock edge that ends the corrupted beat clears the trigger, so control bit 8 reads 0 afterwards. The following beat passes through unchanged. The pattern and writeback fields keep their values.
- R6: Cycles in which `enc_valid_i` is low neither corrupt the check byte nor consume the armed trigger.
- R7: While the trigger is pending, control-register writes are ignored. The pattern and writeback fields keep their armed values, and those armed values are the ones applied to the next beat.
- R8: `mem_wb_en_o` is 1 only on the corrupted beat, and only when the writeback flag was set.
- R9: Status register (byte offset 4) bit 0 follows `wr_pend_i` and all its other bits read 0. Any other offset reads 0.
- R10: A control write with bit 8 equal to 0 while idle updates the pattern and writeback fields but does not arm. The next beat passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from address) |
| wr_pend_i | input | 1 | Controller has writes in flight |
| enc_valid_i | input | 1 | Encoder write beat valid |
| enc_check_i | input | 8 | Check byte from the encoder |
| mem_valid_o | output | 1 | Write beat valid toward memory |
| mem_check_o | output | 8 | Check byte toward memory, possibly corrupted |
| mem_wb_en_o | output | 1 | Writeback request accompanying a corrupted beat |

## Verification
The injection path is tried with several pattern types:
- single-column data-bit syndromes such as 0xF4 and 0x0B, which show that every pattern bit reaches its own check bit;
- one-hot check-bit flips at both ends of the byte, which expose any bit-order reversal;
- 0x03 without writeback, which must flip two bits and raise no writeback request;
- an all-zero pattern, which shows that an armed beat is consumed even when nothing visibly changes.

Each armed pattern is paired with a different incoming check byte. This tells a true XOR apart from a plain replace or an OR. Idle cycles between arming and the beat show that only valid beats consume the trigger.

// File: rtl/eccinj_pkg.sv
package eccinj_pkg;
    localparam int REG_W    = 32;
    localparam int CHK_W    = 8;
    localparam int PAT_LSB  = 16;
    localparam int WB_BIT   = 24;
    localparam int TRIG_BIT = 8;
    localparam int BUSY_BIT = 0;

    typedef struct packed {
        logic [CHK_W-1:0] pattern;
        logic             wb_en;
        logic             armed;
    } inj_state_t;
endpackage

// File: rtl/eccinj_regs.sv
module eccinj_regs
    import eccinj_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    output logic [REG_W-1:0]  reg_rdata_o,
    input  logic              wr_pend_i,
    input  logic              consume_i,
    output inj_state_t        state_o
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    inj_state_t st_d, st_q;
    logic       ctrl_wr;

    assign ctrl_wr = reg_we_i && (reg_addr_i == CTRL_A);

    always_comb begin
        st_d = st_q;
        if (consume_i) begin
            st_d.armed = 1'b0;
        end else if (ctrl_wr && !st_q.armed) begin
            st_d.pattern = reg_wdata_i[PAT_LSB +: CHK_W];
            st_d.wb_en   = reg_wdata_i[WB_BIT];
            st_d.armed   = reg_wdata_i[TRIG_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == CTRL_A) begin
            reg_rdata_o[PAT_LSB +: CHK_W] = st_q.pattern;
            reg_rdata_o[WB_BIT]           = st_q.wb_en;
            reg_rdata_o[TRIG_BIT]         = st_q.armed;
        end else if (reg_addr_i == STAT_A) begin
            reg_rdata_o[BUSY_BIT] = wr_pend_i;
        end
    end

    assign state_o = st_q;

    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata_i[REG_W-1:WB_BIT+1], reg_wdata_i[PAT_LSB-1:TRIG_BIT+1],
                            reg_wdata_i[TRIG_BIT-1:0]};

    // R7
    armed_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.armed && ctrl_wr && !consume_i) |=> ($stable(st_q.pattern) && $stable(st_q.wb_en) && st_q.armed));

    // R5
    trigger_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        consume_i |=> (!st_q.armed && $stable(st_q.pattern)));
endmodule

// File: rtl/eccinj_xor.sv
module eccinj_xor
    import eccinj_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  inj_state_t       state_i,
    input  logic             enc_valid_i,
    input  logic [CHK_W-1:0] enc_check_i,
    output logic             mem_valid_o,
    output logic [CHK_W-1:0] mem_check_o,
    output logic             mem_wb_en_o,
    output logic             consume_o
);
    logic hit;
    assign hit = enc_valid_i && state_i.armed;

    for (genvar i = 0; i < CHK_W; i++) begin : g_bit
        assign mem_check_o[i] = enc_check_i[i] ^ (hit & state_i.pattern[i]);
    end

    assign mem_valid_o = enc_valid_i;
    assign mem_wb_en_o = hit && state_i.wb_en;
    assign consume_o   = hit;

    // R2
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !state_i.armed |-> (mem_check_o == enc_check_i && !mem_wb_en_o));

    // R4
    flip_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($countones(mem_check_o ^ enc_check_i) == $countones(state_i.pattern)));

    // R8
    wb_only_on_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wb_en_o |-> (enc_valid_i && state_i.armed));
endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
    import eccinj_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int STAT_ADDR = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [31:0]       reg_wdata_i,
    output logic [31:0]       reg_rdata_o,
    input  logic              wr_pend_i,
    input  logic              enc_valid_i,
    input  logic [7:0]        enc_check_i,
    output logic              mem_valid_o,
    output logic [7:0]        mem_check_o,
    output logic              mem_wb_en_o
);
    inj_state_t state;
    logic       consume;

    eccinj_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .wr_pend_i   (wr_pend_i),
        .consume_i   (consume),
        .state_o     (state)
    );

    eccinj_xor u_xor (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_i     (state),
        .enc_valid_i (enc_valid_i),
        .enc_check_i (enc_check_i),
        .mem_valid_o (mem_valid_o),
        .mem_check_o (mem_check_o),
        .mem_wb_en_o (mem_wb_en_o),
        .consume_o   (consume)
    );

    // R6
    idle_no_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enc_valid_i && state.armed) |=> state.armed);
endmodule

// File: tb/ecc_inject_ctrl_tb.sv
module ecc_inject_ctrl_tb;
    localparam int ADDR_W = 4;
    localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd4;
    localparam logic [ADDR_W-1:0] A_NONE = 4'd8;

    typedef struct packed {
        logic [7:0] pat;
        logic       wb;
        logic [7:0] chk;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{pat: 8'hF4, wb: 1'b1, chk: 8'h00},
        '{pat: 8'h0B, wb: 1'b1, chk: 8'hFF},
        '{pat: 8'h80, wb: 1'b1, chk: 8'h5A},
        '{pat: 8'h01, wb: 1'b1, chk: 8'hA5},
        '{pat: 8'h03, wb: 1'b0, chk: 8'h3C},
        '{pat: 8'h00, wb: 1'b0, chk: 8'h77},
        '{pat: 8'hE9, wb: 1'b1, chk: 8'h81},
        '{pat: 8'h4A, wb: 1'b0, chk: 8'h4A}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_we_i = 1'b0;
    logic [ADDR_W-1:0] reg_addr_i = '0;
    logic [31:0]       reg_wdata_i = '0;
    logic [31:0]       reg_rdata_o;
    logic              wr_pend_i = 1'b0;
    logic              enc_valid_i = 1'b0;
    logic [7:0]        enc_check_i = '0;
    logic              mem_valid_o;
    logic [7:0]        mem_check_o;
    logic              mem_wb_en_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ecc_inject_ctrl #(.ADDR_W(ADDR_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .wr_pend_i(wr_pend_i),
        .enc_valid_i(enc_valid_i), .enc_check_i(enc_check_i), .mem_valid_o(mem_valid_o),
        .mem_check_o(mem_check_o), .mem_wb_en_o(mem_wb_en_o)
    );

    function automatic logic [31:0] ctrl_word(logic [7:0] pat, logic wb, logic trig);
        return {7'd0, wb, pat, 7'd0, trig, 8'd0};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [ADDR_W-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0; reg_wdata_i = '0;
    endtask

    task automatic reg_read(logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr_i = a;
        #1 d = reg_rdata_o;
    endtask

    task automatic beat(logic [7:0] c, output logic [7:0] mc, output logic wb, output logic mv);
        @(negedge clk);
        enc_valid_i = 1'b1; enc_check_i = c;
        #1 mc = mem_check_o; wb = mem_wb_en_o; mv = mem_valid_o;
        @(negedge clk);
        enc_valid_i = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [7:0]  mc;
        logic        wb, mv;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(A_CTRL, rd);  check("R1 ctrl after reset", rd, 32'h0);
        reg_read(A_STAT, rd);  check("R1 status after reset", rd, 32'h0);
        beat(8'h9C, mc, wb, mv);
        check("R1 passthrough after reset", {23'd0, wb, mc}, {23'd0, 1'b0, 8'h9C});

        // R2 unarmed beats pass through
        beat(8'hFF, mc, wb, mv);
        check("R2 passthrough 0xFF", {22'd0, mv, wb, mc}, {22'd0, 1'b1, 1'b0, 8'hFF});
        beat(8'h00, mc, wb, mv);
        check("R2 passthrough 0x00", {23'd0, wb, mc}, 32'h0);

        // R9 status and unmapped offset
        wr_pend_i = 1'b1;
        reg_read(A_STAT, rd);  check("R9 status pending", rd, 32'h1);
        reg_read(A_NONE, rd);  check("R9 unmapped reads zero", rd, 32'h0);
        wr_pend_i = 1'b0;
        reg_read(A_STAT, rd);  check("R9 status idle", rd, 32'h0);

        // Vector table: R3 arm, R6 idle gap, R4/R8 corrupted beat, R5 self-clear
        for (int i = 0; i < NV; i++) begin
            reg_write(A_CTRL, ctrl_word(VECS[i].pat, VECS[i].wb, 1'b1) | 32'hFE00_FEFF);
            reg_read(A_CTRL, rd);
            check("R3 armed readback", rd, ctrl_word(VECS[i].pat, VECS[i].wb, 1'b1));
            @(negedge clk);
            enc_check_i = VECS[i].chk;
            #1 check("R6 idle cycle no corruption", {24'd0, mem_check_o}, {24'd0, VECS[i].chk});
            repeat (2) @(negedge clk);
            beat(VECS[i].chk, mc, wb, mv);
            check("R4 corrupted check byte", {24'd0, mc}, {24'd0, VECS[i].chk ^ VECS[i].pat});
            check("R8 writeback flag on beat", {31'd0, wb}, {31'd0, VECS[i].wb});
            reg_read(A_CTRL, rd);
            check("R5 trigger cleared, fields kept", rd, ctrl_word(VECS[i].pat, VECS[i].wb, 1'b0));
            beat(VECS[i].chk, mc, wb, mv);
            check("R5 next beat unmodified", {23'd0, wb, mc}, {23'd0, 1'b0, VECS[i].chk});
        end

        // R4 uncorrectable pattern flips exactly bits 1 and 0
        reg_write(A_CTRL, ctrl_word(8'h03, 1'b0, 1'b1));
        beat(8'h00, mc, wb, mv);
        check("R4 0x03 flips bits 1:0", {23'd0, wb, mc}, {23'd0, 1'b0, 8'h03});

        // R7 writes while armed are ignored
        reg_write(A_CTRL, ctrl_word(8'h11, 1'b1, 1'b1));
        reg_write(A_CTRL, ctrl_word(8'hC0, 1'b0, 1'b0));
        reg_read(A_CTRL, rd);
        check("R7 armed write ignored", rd, ctrl_word(8'h11, 1'b1, 1'b1));
        beat(8'h0F, mc, wb, mv);
        check("R7 armed pattern applied", {23'd0, wb, mc}, {23'd0, 1'b1, 8'h1E});

        // R10 write without trigger does not arm
        reg_write(A_CTRL, ctrl_word(8'h5A, 1'b1, 1'b0));
        reg_read(A_CTRL, rd);
        check("R10 fields updated, not armed", rd, ctrl_word(8'h5A, 1'b1, 1'b0));
        beat(8'h33, mc, wb, mv);
        check("R10 beat unmodified", {23'd0, wb, mc}, {23'd0, 1'b0, 8'h33});

        // R1 reset while armed returns to idle
        reg_write(A_CTRL, ctrl_word(8'hFF, 1'b1, 1'b1));
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        reg_read(A_CTRL, rd);  check("R1 reset clears armed state", rd, 32'h0);
        beat(8'h42, mc, wb, mv);
        check("R1 passthrough after re-reset", {23'd0, wb, mc}, {23'd0, 1'b0, 8'h42});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule